// File: doc/BRIEF.md
# Variable-Precision Bit-Serial Multiply-Accumulator

This block multiplies an unsigned parallel operand by a second unsigned operand that arrives one bit per clock cycle, most significant bit first. A per-operation bit count sets how many serial bits belong to the current value. Each shift cycle doubles a partial product and, when the incoming bit is one, adds the parallel operand to it. A low-precision value therefore finishes in fewer cycles than a full-width one. When the last bit has been taken in, the finished product is added to or subtracted from a signed running sum, as a per-operation sign flag selects. A clear input empties the sum.

The controller is a three-state machine. The states are `ST_IDLE` (waiting for a request), `ST_SHIFT` (taking in one serial bit per cycle) and `ST_FOLD` (merging the product into the sum). The transitions are named as follows:
- `idle->shift` is taken on an accepted start with a non-zero count.
- `idle->fold` is taken on an accepted start with a zero count.
- `shift->shift` is taken while more than one bit is still outstanding.
- `shift->fold` is taken on the last bit.
- `fold->idle` is taken unconditionally.

The done strobe is registered from the fold cycle, so it appears in the cycle after the sum has been updated.

Top module: `bsmac_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy_o` and `done_o` are 0 and `acc_o` is 0.
- R2: A start seen while `busy_o` is 0 is accepted. `busy_o` is 1 from the next cycle until the done cycle. `done_o` is 1 for exactly one cycle, and in that cycle `busy_o` is 0.
- R3: With an effective bit count n, `done_o` is high in the (n+2)-th cycle after the clock edge that accepted the start.
- R4: The serial bit sampled at the k-th edge after acceptance (k = 1..n) has weight 2^(n-k). The product is the parallel operand times the n-bit serial value.
- R5: In the done cycle, `acc_o` equals the previous sum plus the product when `sub_i` was 0 at acceptance.
- R6: When `sub_i` was 1 at acceptance, the product is subtracted instead. `acc_o` is two's complement of width OP_W+MAX_BITS+clog2(ACC_OPS)+1.
- R7: A bit count of 0 consumes no serial bits, produces a zero product, and raises done 2 cycles after acceptance.
- R8: A bit count above MAX_BITS is treated as MAX_BITS, for both latency and product.
- R9: A start asserted while `busy_o` is 1 is ignored. Its operand, count and sign flag change neither the timing nor the result of the operation in progress.
- R10: `clr_i` asserted while idle makes `acc_o` 0 in the next cycle.
- R11: `clr_i` asserted in the fold cycle, which is the cycle before done, starts a fresh sum. In the done cycle `acc_o` equals the signed product alone.
- R12: While idle and not cleared, `acc_o` holds its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a new multiply-accumulate |
| cnt_i | input | CNT_W | Number of serial bits, sampled with start |
| opnd_i | input | OP_W | Parallel operand, sampled with start |
| sub_i | input | 1 | Sign flag: 1 subtracts the product from the sum |
| bit_i | input | 1 | Serial operand bit, MSB first, one per shift cycle |
| clr_i | input | 1 | Clear the running sum |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle strobe: the sum holds the new result |
| acc_o | output | ACC_W | Signed running sum |

## Verification
The bound checker checks several properties on every cycle:
- The done pulse lasts one cycle and never overlaps busy (R2).
- The done strobe lands exactly the effective count plus two cycles after acceptance, with starts during busy ignored and large counts clamped (R3, R8, R9).
- An idle clear zeroes the sum, and an idle sum holds still otherwise (R10, R12).

The arithmetic can only be shown by the bench's scenarios, because the checker has no model of the product. These scenarios cover MSB-first weighting, accumulation and subtraction, the zero count, and a clear that coincides with the fold. They compare `acc_o` against a sum computed from the operands.

// File: rtl/bsmac_pkg.sv
package bsmac_pkg;

    // Controller states of the bit-serial multiply-accumulator
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FOLD  = 2'd2
    } bsmac_state_e;

endpackage

// File: rtl/bsmac_ctrl.sv
module bsmac_ctrl
    import bsmac_pkg::*;
#(
    parameter int MAX_BITS = 8,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             load_o,
    output logic             shift_o,
    output logic             fold_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam int REM_W = $clog2(MAX_BITS + 1);

    bsmac_state_e     state_q, state_d;
    logic [REM_W-1:0] rem_q, rem_d;
    logic [REM_W-1:0] cnt_eff;
    logic             done_q;

    // Clamp the requested precision to the supported maximum
    always_comb begin
        if (cnt_i > CNT_W'(MAX_BITS)) begin
            cnt_eff = REM_W'(MAX_BITS);
        end else begin
            cnt_eff = cnt_i[REM_W-1:0];
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    rem_d   = cnt_eff;
                    state_d = (cnt_eff == '0) ? ST_FOLD : ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                rem_d = rem_q - 1'b1;
                if (rem_q == REM_W'(1)) begin
                    state_d = ST_FOLD;
                end
            end
            ST_FOLD: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Output decode
    always_comb begin
        load_o  = 1'b0;
        shift_o = 1'b0;
        fold_o  = 1'b0;
        busy_o  = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
                load_o = start_i;
            end
            ST_SHIFT: begin
                shift_o = 1'b1;
            end
            ST_FOLD: begin
                fold_o = 1'b1;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

    // Done strobe follows the fold cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= fold_o;
        end
    end

    assign done_o = done_q;

endmodule

// File: rtl/bsmac_shift.sv
module bsmac_shift #(
    parameter int OP_W   = 8,
    parameter int PROD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [OP_W-1:0]   opnd_i,
    input  logic              sub_i,
    input  logic              bit_i,
    output logic [PROD_W-1:0] prod_o,
    output logic              neg_o
);

    logic [OP_W-1:0]   opnd_q;
    logic              neg_q;
    logic [PROD_W-1:0] part_q;
    logic [PROD_W-1:0] addend;

    assign addend = bit_i ? PROD_W'(opnd_q) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opnd_q <= '0;
            neg_q  <= 1'b0;
            part_q <= '0;
        end else if (load_i) begin
            opnd_q <= opnd_i;
            neg_q  <= sub_i;
            part_q <= '0;
        end else if (shift_i) begin
            // Double the partial product, then add on a one bit
            part_q <= {part_q[PROD_W-2:0], 1'b0} + addend;
        end
    end

    assign prod_o = part_q;
    assign neg_o  = neg_q;

endmodule

// File: rtl/bsmac_accum.sv
module bsmac_accum #(
    parameter int PROD_W = 16,
    parameter int ACC_W  = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              fold_i,
    input  logic [PROD_W-1:0] prod_i,
    input  logic              neg_i,
    output logic [ACC_W-1:0]  acc_o
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] ext;
    logic [ACC_W-1:0] term;
    logic [ACC_W-1:0] base;

    assign ext  = ACC_W'(prod_i);
    assign term = fold_i ? (neg_i ? (~ext + 1'b1) : ext) : '0;
    assign base = clr_i ? '0 : acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr_i || fold_i) begin
            acc_q <= base + term;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/bsmac_top.sv
module bsmac_top #(
    parameter int OP_W     = 8,
    parameter int MAX_BITS = 8,
    parameter int CNT_W    = 4,
    parameter int ACC_OPS  = 16,
    localparam int PROD_W  = OP_W + MAX_BITS,
    localparam int ACC_W   = PROD_W + $clog2(ACC_OPS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [OP_W-1:0]  opnd_i,
    input  logic             sub_i,
    input  logic             bit_i,
    input  logic             clr_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [ACC_W-1:0] acc_o
);

    logic              load;
    logic              shift;
    logic              fold;
    logic [PROD_W-1:0] prod;
    logic              neg;

    bsmac_ctrl #(
        .MAX_BITS (MAX_BITS),
        .CNT_W    (CNT_W)
    ) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .cnt_i   (cnt_i),
        .load_o  (load),
        .shift_o (shift),
        .fold_o  (fold),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    bsmac_shift #(
        .OP_W   (OP_W),
        .PROD_W (PROD_W)
    ) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .opnd_i  (opnd_i),
        .sub_i   (sub_i),
        .bit_i   (bit_i),
        .prod_o  (prod),
        .neg_o   (neg)
    );

    bsmac_accum #(
        .PROD_W (PROD_W),
        .ACC_W  (ACC_W)
    ) accum_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_i),
        .fold_i (fold),
        .prod_i (prod),
        .neg_i  (neg),
        .acc_o  (acc_o)
    );

endmodule

// File: rtl/bsmac_chk.sv
module bsmac_chk #(
    parameter int MAX_BITS = 8,
    parameter int CNT_W    = 4,
    parameter int ACC_W    = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic             clr_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [ACC_W-1:0] acc_o
);

    // Latency window tracked by counters rather than long delays
    logic [7:0] lat_exp_q;
    logic [7:0] lat_el_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_exp_q <= '0;
            lat_el_q  <= '0;
        end else if (start_i && !busy_o) begin
            lat_exp_q <= (cnt_i > CNT_W'(MAX_BITS)) ? 8'(MAX_BITS + 1) : 8'(cnt_i) + 8'd1;
            lat_el_q  <= '0;
        end else if (busy_o) begin
            lat_el_q  <= lat_el_q + 8'd1;
        end
    end

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R2
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R2
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_el_q == lat_exp_q)); // R3 R8 R9
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !busy_o) |=> (acc_o == '0)); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !clr_i) |=> $stable(acc_o)); // R12

endmodule

bind bsmac_top bsmac_chk #(
    .MAX_BITS (MAX_BITS),
    .CNT_W    (CNT_W),
    .ACC_W    (ACC_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .cnt_i   (cnt_i),
    .clr_i   (clr_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .acc_o   (acc_o)
);

// File: tb/bsmac_top_tb.sv
`timescale 1ns/1ps
module bsmac_top_tb_top;

    localparam int ACC_W = 21;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [3:0]       cnt_i = '0;
    logic [7:0]       opnd_i = '0;
    logic             sub_i = 1'b0;
    logic             bit_i = 1'b0;
    logic             clr_i = 1'b0;
    logic             busy_o;
    logic             done_o;
    logic [ACC_W-1:0] acc_o;

    int      n_cmp  = 0;
    int      n_bad  = 0;
    bit      ended  = 1'b0;
    longint  acc_exp = 0;

    always #2.5 clk = ~clk;

    bsmac_top dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .cnt_i   (cnt_i),
        .opnd_i  (opnd_i),
        .sub_i   (sub_i),
        .bit_i   (bit_i),
        .clr_i   (clr_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .acc_o   (acc_o)
    );

    // Vector fields: {sub, count, operand, serial value}
    localparam logic [20:0] VEC [8] = '{
        {1'b0, 4'd8, 8'd255, 8'd255},
        {1'b0, 4'd4, 8'd13,  8'd11},
        {1'b1, 4'd8, 8'd100, 8'd200},
        {1'b0, 4'd1, 8'd77,  8'd1},
        {1'b0, 4'd3, 8'd200, 8'd5},
        {1'b1, 4'd2, 8'd50,  8'd3},
        {1'b0, 4'd8, 8'd1,   8'd128},
        {1'b0, 4'd5, 8'd9,   8'd16}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // One complete operation, checked at every cycle up to done
    task automatic run_op(input logic [7:0] op, input logic [3:0] n,
                          input logic [7:0] v, input bit sb,
                          input bit clr_fold, input bit extra, input string req);
        int     eff;
        longint prod;
        eff  = (n > 4'd8) ? 8 : int'(n);
        prod = longint'(op) * (longint'(v) & ((64'd1 << eff) - 1));
        if (sb) prod = -prod;
        @(negedge clk);
        start_i = 1'b1; cnt_i = n; opnd_i = op; sub_i = sb; bit_i = 1'b0;
        for (int k = 1; k <= eff + 2; k++) begin
            @(negedge clk);
            start_i = 1'b0;
            clr_i   = 1'b0;
            bit_i   = (k <= eff) ? v[eff-k] : 1'b0;
            if (extra && k == 2) begin
                start_i = 1'b1; cnt_i = 4'd1; opnd_i = 8'hFF; sub_i = ~sb;
            end
            if (clr_fold && k == eff + 1) clr_i = 1'b1;
            if (k < eff + 2) begin
                check(busy_o && !done_o, req, "busy without done", {busy_o, done_o}, 2);
            end else begin
                check(done_o && !busy_o, req, "done strobe timing", {busy_o, done_o}, 1);
            end
        end
        if (clr_fold) acc_exp = prod;
        else          acc_exp = acc_exp + prod;
        check(acc_o == ACC_W'(acc_exp), req, "sum", longint'($signed(acc_o)), acc_exp);
        @(negedge clk);
        check(!done_o, req, "done one cycle", done_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && acc_o == '0, "R1", "in reset", acc_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && acc_o == '0, "R1", "after reset", acc_o, 0);

        // R4 R5 R6: vector table walk
        foreach (VEC[i]) begin
            run_op(VEC[i][15:8], VEC[i][19:16], VEC[i][7:0], VEC[i][20], 1'b0, 1'b0, "R4_R5_R6");
        end

        // R7: zero count
        run_op(8'd200, 4'd0, 8'd255, 1'b0, 1'b0, 1'b0, "R7");
        // R8: count above maximum clamps to eight bits
        run_op(8'd3, 4'd12, 8'hA5, 1'b0, 1'b0, 1'b0, "R8");
        // R9: start during busy is ignored
        run_op(8'd21, 4'd6, 8'd45, 1'b0, 1'b0, 1'b1, "R9");

        // R12: idle hold while other inputs toggle
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            bit_i = c[0]; opnd_i = 8'(c * 37); cnt_i = 4'(c);
            check(acc_o == ACC_W'(acc_exp), "R12", "idle hold", longint'($signed(acc_o)), acc_exp);
        end

        // R10: idle clear
        @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        acc_exp = 0;
        check(acc_o == '0, "R10", "idle clear", longint'($signed(acc_o)), 0);

        // R11: clear coinciding with fold
        run_op(8'd10, 4'd3, 8'd7, 1'b0, 1'b0, 1'b0, "R5");
        run_op(8'd15, 4'd4, 8'd9, 1'b1, 1'b1, 1'b0, "R11");

        // R2 R3: back-to-back operations after done
        run_op(8'd2, 4'd2, 8'd2, 1'b0, 1'b0, 1'b0, "R2_R3");

        summary();
    end

endmodule